// File: doc/BRIEF.md
# Register-Operate Execute Unit with Condition Codes

This block is the single-cycle execute stage of a small 16-bit load/store processor. It accepts one instruction word per cycle, qualified by a valid strobe. It recognises three operate functions: two's-complement addition, bitwise AND and bitwise inversion. Operands come from an eight-entry register file. The second operand of an add or an AND is either another register or a 5-bit literal carried in the instruction. The result goes back into a destination register. There is no subtract function. Software subtracts by inverting the subtrahend, adding one, then adding.

Every register write also refreshes three separate one-hot condition flags. These flags report whether the written value is negative, zero or positive. A combinational debug port shows any register, and the flags are always driven out. A word that is not a well-formed operate instruction changes nothing.

Top module: `opx_exec`

## Requirements
- R1: While reset is low, and after it is released, all eight registers read zero and the flags are N=0, Z=1, P=0.
- R2: With `insn[15:12]`=0001, `insn[5]`=0 and `insn[4:3]`=00, the register named by `insn[11:9]` receives `reg[insn[8:6]] + reg[insn[2:0]]`, modulo 2^16.
- R3: With `insn[15:12]`=0001 and `insn[5]`=1, the destination receives `reg[insn[8:6]]` plus `insn[4:0]` sign-extended to 16 bits, modulo 2^16.
- R4: With `insn[15:12]`=0101, the destination receives the bitwise AND of `reg[insn[8:6]]` with the second operand. The second operand is chosen exactly as in R2 and R3.
- R5: With `insn[15:12]`=1001 and `insn[5:0]`=111111, the destination receives the bitwise inverse of `reg[insn[8:6]]`.
- R6: After every register write, exactly one flag is 1. N=1 when bit 15 of the written value is 1. Z=1 when the value is zero. P=1 otherwise.
- R7: No register is written and the flags keep their value in each of these cases: `insn_valid` is low; the opcode is not one of 0001, 0101 or 1001; an add or AND has `insn[5]`=0 and `insn[4:3]` not 00; an inversion has `insn[5:0]` other than 111111.
- R8: The result and the new flags become visible at the rising edge that samples the valid instruction. Sources are read before the write, so a destination may equal a source.
- R9: `dbg_data` shows, combinationally, the current contents of the register selected by `dbg_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn | input | 16 | Instruction word |
| dbg_sel | input | 3 | Register index for the debug read |
| dbg_data | output | 16 | Contents of the selected register |
| flag_neg | output | 1 | Last written value was negative |
| flag_zero | output | 1 | Last written value was zero |
| flag_pos | output | 1 | Last written value was positive |

## Verification
The assertions assume that `rst_n` goes high away from a rising clock edge, and that `insn` and `insn_valid` are settled well before each edge. The assertions that tie the flags to the result also assume that the instruction ports hold no unknown bits. The bench meets these assumptions by changing inputs only at falling edges and releasing reset between edges. It drives only fully defined words, from a directed list and from a random generator. The random generator deliberately mixes in malformed and unassigned opcodes, so the R7 cases appear among legal traffic.

// File: rtl/opx_pkg.sv
package opx_pkg;
  localparam int unsigned XLEN = 16;
  localparam int unsigned NREG = 8;
  localparam int unsigned RIDX = $clog2(NREG);
  localparam int unsigned LITW = 5;
  localparam int unsigned OPCW = 4;

  localparam logic [OPCW-1:0] OPC_ADD = 4'b0001;
  localparam logic [OPCW-1:0] OPC_AND = 4'b0101;
  localparam logic [OPCW-1:0] OPC_NOT = 4'b1001;

  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_AND = 2'd1,
    FN_NOT = 2'd2
  } fn_e;

  typedef struct packed {
    logic            we;
    fn_e             fn;
    logic [RIDX-1:0] rd;
    logic [RIDX-1:0] rs1;
    logic [RIDX-1:0] rs2;
    logic            use_lit;
    logic [XLEN-1:0] lit;
  } dec_t;
endpackage

// File: rtl/opx_decode.sv
module opx_decode
  import opx_pkg::*;
(
  input  logic            valid,
  input  logic [XLEN-1:0] insn,
  output dec_t            dec
);
  logic [OPCW-1:0] opc;
  logic            reg_form_ok;

  always_comb begin
    opc         = insn[15:12];
    reg_form_ok = insn[5] | (insn[4:3] == 2'b00);
    dec.rd      = insn[11:9];
    dec.rs1     = insn[8:6];
    dec.rs2     = insn[2:0];
    dec.use_lit = insn[5];
    dec.lit     = {{(XLEN-LITW){insn[LITW-1]}}, insn[LITW-1:0]};
    dec.fn      = FN_ADD;
    dec.we      = 1'b0;
    if (valid) begin
      if (opc == OPC_ADD) begin
        dec.fn = FN_ADD;
        dec.we = reg_form_ok;
      end else if (opc == OPC_AND) begin
        dec.fn = FN_AND;
        dec.we = reg_form_ok;
      end else if (opc == OPC_NOT) begin
        dec.fn = FN_NOT;
        dec.we = (insn[5:0] == 6'b111111);
      end
    end
  end
endmodule

// File: rtl/opx_alu.sv
module opx_alu
  import opx_pkg::*;
(
  input  fn_e             fn,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  always_comb begin
    case (fn)
      FN_ADD:  y = a + b;
      FN_AND:  y = a & b;
      FN_NOT:  y = ~a;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/opx_regfile.sv
module opx_regfile
  import opx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [RIDX-1:0] waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [RIDX-1:0] ra_a,
  input  logic [RIDX-1:0] ra_b,
  input  logic [RIDX-1:0] ra_d,
  output logic [XLEN-1:0] rd_a,
  output logic [XLEN-1:0] rd_b,
  output logic [XLEN-1:0] rd_d
);
  logic [XLEN-1:0] mem_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    logic            en;
    logic [XLEN-1:0] nxt;

    always_comb begin
      en  = we && (waddr == RIDX'(i));
      nxt = en ? wdata : mem_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[i] <= '0;
      else        mem_q[i] <= nxt;
    end
  end

  assign rd_a = mem_q[ra_a];
  assign rd_b = mem_q[ra_b];
  assign rd_d = mem_q[ra_d];

  // R8: a write lands in the addressed entry by the following cycle
  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem_q[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/opx_ccode.sv
module opx_ccode
  import opx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd,
  input  logic [XLEN-1:0] wdata,
  output logic            flag_n,
  output logic            flag_z,
  output logic            flag_p
);
  logic [2:0] cc_q, cc_d;

  always_comb begin
    cc_d = cc_q;
    if (upd) begin
      if (wdata[XLEN-1])       cc_d = 3'b100;
      else if (wdata == '0)    cc_d = 3'b010;
      else                     cc_d = 3'b001;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cc_q <= 3'b010;
    else        cc_q <= cc_d;
  end

  assign {flag_n, flag_z, flag_p} = cc_q;

  // R6: exactly one flag is set at all times
  a_r6_flags_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cc_q) == 1);
endmodule

// File: rtl/opx_exec.sv
module opx_exec
  import opx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_valid,
  input  logic [15:0]     insn,
  input  logic [2:0]      dbg_sel,
  output logic [15:0]     dbg_data,
  output logic            flag_neg,
  output logic            flag_zero,
  output logic            flag_pos
);
  dec_t            dec;
  logic [XLEN-1:0] src_a, src_b, op_b, result;

  opx_decode u_dec (
    .valid (insn_valid),
    .insn  (insn),
    .dec   (dec)
  );

  opx_regfile u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (dec.we),
    .waddr (dec.rd),
    .wdata (result),
    .ra_a  (dec.rs1),
    .ra_b  (dec.rs2),
    .ra_d  (dbg_sel),
    .rd_a  (src_a),
    .rd_b  (src_b),
    .rd_d  (dbg_data)
  );

  assign op_b = dec.use_lit ? dec.lit : src_b;

  opx_alu u_alu (
    .fn (dec.fn),
    .a  (src_a),
    .b  (op_b),
    .y  (result)
  );

  opx_ccode u_cc (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd    (dec.we),
    .wdata  (result),
    .flag_n (flag_neg),
    .flag_z (flag_zero),
    .flag_p (flag_pos)
  );

  // R5: a well-formed inversion always writes
  a_r5_not_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn[15:12] == 4'b1001 && insn[5:0] == 6'h3f) |-> dec.we);

  // R7: a malformed register-form add never writes
  a_r7_bad_regform: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn[15:12] == 4'b0001 && !insn[5] && insn[4:3] != 2'b00)
    |-> !dec.we);

  // R7: an unassigned opcode leaves the flags unchanged
  a_r7_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn[15:12] == 4'b0011)
    |=> $stable({flag_neg, flag_zero, flag_pos}));

  // R6: the negative flag follows the sign of the value just written
  a_r6_sign_flag: assert property (@(posedge clk) disable iff (!rst_n)
    dec.we |=> (flag_neg == $past(result[XLEN-1])));
endmodule

// File: tb/sim_opx_exec.sv
`timescale 1ns/1ps
module sim_opx_exec;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        insn_valid;
  logic [15:0] insn;
  logic [2:0]  dbg_sel;
  logic [15:0] dbg_data;
  logic        flag_neg, flag_zero, flag_pos;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [15:0] mreg [8];
  logic [2:0]  mcc;

  always #2 clk = ~clk;

  opx_exec u0 (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
    .dbg_sel(dbg_sel), .dbg_data(dbg_data),
    .flag_neg(flag_neg), .flag_zero(flag_zero), .flag_pos(flag_pos)
  );

  function automatic logic [15:0] enc(input logic [3:0] opc, input int rd,
                                      input int rs1, input logic [5:0] tail);
    enc = {opc, 3'(rd), 3'(rs1), tail};
  endfunction

  task automatic model(input logic v, input logic [15:0] ins);
    logic [15:0] a, b, res;
    logic        we, ok;
    we  = 1'b0;
    res = '0;
    a   = mreg[ins[8:6]];
    b   = ins[5] ? {{11{ins[4]}}, ins[4:0]} : mreg[ins[2:0]];
    ok  = ins[5] || (ins[4:3] == 2'b00);
    if (v) begin
      if (ins[15:12] == 4'b0001 && ok)              begin res = a + b; we = 1'b1; end
      else if (ins[15:12] == 4'b0101 && ok)         begin res = a & b; we = 1'b1; end
      else if (ins[15:12] == 4'b1001 && ins[5:0] == 6'h3f) begin res = ~a; we = 1'b1; end
    end
    if (we) begin
      mreg[ins[11:9]] = res;
      if (res[15])        mcc = 3'b100;
      else if (res == 0)  mcc = 3'b010;
      else                mcc = 3'b001;
    end
  endtask

  task automatic check_all(input string tag);
    checks++;
    if ({flag_neg, flag_zero, flag_pos} !== mcc) begin
      errors++;
      $display("FAIL %s flags: actual %b expected %b", tag,
               {flag_neg, flag_zero, flag_pos}, mcc);
    end
    for (int i = 0; i < 8; i++) begin
      dbg_sel = 3'(i);
      #0.1;
      checks++;
      if (dbg_data !== mreg[i]) begin
        errors++;
        $display("FAIL %s reg%0d: actual %h expected %h", tag, i, dbg_data, mreg[i]);
      end
    end
  endtask

  task automatic step(input logic v, input logic [15:0] ins, input string tag);
    @(negedge clk);
    insn_valid = v;
    insn       = ins;
    model(v, ins);
    @(posedge clk);
    #1;
    check_all(tag);
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; insn_valid = 1'b0; insn = '0; dbg_sel = '0;
    for (int i = 0; i < 8; i++) mreg[i] = '0;
    mcc = 3'b010;
    #9;
    check_all("R1 in reset, R9 debug read");
    rst_n = 1'b1;
    @(posedge clk); #1;
    check_all("R1 after release");

    step(1, enc(4'b0001, 1, 0, 6'b100101), "R3 add +5");
    step(1, enc(4'b0001, 2, 0, 6'b110000), "R3 add -16, R6 neg");
    step(1, enc(4'b0001, 3, 1, 6'b000010), "R2 add regs");
    step(1, enc(4'b0101, 4, 2, 6'b101100), "R4 and literal");
    step(1, enc(4'b0101, 5, 3, 6'b000001), "R4 and regs");
    step(1, enc(4'b1001, 6, 2, 6'b111111), "R5 not");
    step(1, enc(4'b0001, 6, 6, 6'b100001), "R8 rd equals rs1");
    step(1, enc(4'b1001, 7, 0, 6'b111111), "R5 not zero");
    step(1, enc(4'b0001, 7, 7, 6'b100001), "R6 wrap to zero");
    step(1, enc(4'b0001, 1, 1, 6'b000001), "R8 add self");
    step(1, enc(4'b0011, 2, 1, 6'b100001), "R7 unassigned opcode");
    step(1, enc(4'b0001, 2, 1, 6'b001001), "R7 bad reg form");
    step(1, enc(4'b0101, 2, 1, 6'b010001), "R7 bad and reg form");
    step(1, enc(4'b1001, 2, 1, 6'b011110), "R7 bad not tail");
    step(0, enc(4'b0001, 2, 1, 6'b100111), "R7 valid low");
    // subtract r1 - r3 by negate and add
    step(1, enc(4'b1001, 5, 3, 6'b111111), "R5 negate step");
    step(1, enc(4'b0001, 5, 5, 6'b100001), "R3 plus one");
    step(1, enc(4'b0001, 5, 1, 6'b000101), "R2 subtract result");

    for (int n = 0; n < 400; n++) begin
      logic [15:0] w;
      logic [1:0]  pick;
      w    = 16'($urandom);
      pick = 2'($urandom);
      case (pick)
        2'd0: w[15:12] = 4'b0001;
        2'd1: w[15:12] = 4'b0101;
        2'd2: begin w[15:12] = 4'b1001; if (w[6]) w[5:0] = 6'h3f; end
        default: ;
      endcase
      if (pick != 2'd2 && w[7] && !w[5]) w[4:3] = 2'b00;
      step(($urandom % 8) != 0, w, "R2 R3 R4 R5 R6 R7 random");
    end

    @(negedge clk);
    insn_valid = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule